// File: doc/BRIEF.md
# Running Disparity Tracker for 10-bit Line Symbols

This block watches a stream of 10-bit symbols that an 8b/10b style encoder has already produced and follows the running disparity across them. Each symbol is split into a leading 6-bit group and a trailing 4-bit group. The leading group is judged first against the disparity carried in from the previous symbol. The trailing group is then judged against the result of the leading group. The result of the trailing group is carried into the next symbol.

A receiver uses the block to spot line corruption that leaves the bit count of a symbol plausible but breaks the alternation the code promises. It reports the disparity after each group and raises a single error flag for the symbol when either group breaks the rules. The block does not map symbols to bytes and holds no code table.

Top module: `rd_tracker`

## Requirements
- R1: After reset, `rd_cur` and `rd_mid` read 0 (negative disparity) and `disp_err` reads 0. Disparity is encoded as 1 = positive, 0 = negative.
- R2: `sym_in[9:4]` (bit 9 leftmost) is the 6-bit group and is judged first against the carried disparity. `rd_mid` shows the result. `sym_in[3:0]` is judged against that result, and `rd_cur` shows the final value, which is carried to the next symbol.
- R3: A group with more ones than zeros makes the disparity positive. A group with more zeros than ones makes it negative.
- R4: A 6-bit group equal to 000111 makes the disparity positive, and one equal to 111000 makes it negative, whatever the entering value.
- R5: A 4-bit group equal to 0011 makes the disparity positive, and one equal to 1100 makes it negative, whatever the entering value.
- R6: Any other group with equal ones and zeros leaves the disparity unchanged.
- R7: `disp_err` is set for a symbol when a group has two more ones than zeros while the disparity entering it is positive. It is also set when a group has two more zeros than ones while the entering disparity is negative.
- R8: `disp_err` is set when the ones minus zeros of either group is outside {-2, 0, +2}. In that case the disparity still follows R3.
- R9: Outputs are registered and change one clock after a cycle with `sym_valid` high. While `sym_valid` is low, all outputs hold their values whatever `sym_in` carries.
- R10: A stream that alternates 0011111010 and 1100000101, starting from negative disparity, never sets `disp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_valid | input | 1 | Symbol on `sym_in` is present this cycle |
| sym_in | input | 10 | Encoded symbol; bits 9..4 form the 6-bit group, bits 3..0 the 4-bit group |
| rd_cur | output | 1 | Running disparity after the last symbol (1 = positive) |
| rd_mid | output | 1 | Disparity after the 6-bit group of the last symbol |
| disp_err | output | 1 | Last symbol broke a disparity or imbalance rule |

## Verification
The hardest situation to reach is a given symbol arriving with a chosen entering disparity, because that disparity is internal state left by earlier traffic. The stimulus sweeps all 1024 symbols from both entering values. Before each swept symbol it sends a rule-abiding setter symbol (000111 0011 or 111000 1100), which forces the carried disparity to the wanted value. Hold behaviour is probed by idle cycles with changing data in between.

// File: rtl/rd_pkg.sv
package rd_pkg;
  typedef enum logic {
    RD_NEG = 1'b0,
    RD_POS = 1'b1
  } rd_e;
endpackage

// File: rtl/rd_rst_sync.sv
module rd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/rd_subblock_eval.sv
module rd_subblock_eval
  import rd_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [W-1:0] bits,
  input  rd_e          rd_in,
  output rd_e          rd_out,
  output logic         sign_err,
  output logic         code_err
);
  localparam int CW = $clog2(W + 1);
  localparam int HALF = W / 2;
  localparam logic [CW-1:0] MID_C   = CW'(HALF);
  localparam logic [CW-1:0] HEAVY_C = CW'(HALF + 1);
  localparam logic [CW-1:0] LIGHT_C = CW'(HALF - 1);
  localparam logic [W-1:0]  POS_PAT = W'((1 << HALF) - 1);
  localparam logic [W-1:0]  NEG_PAT = ~POS_PAT;

  logic [CW-1:0] ones;
  logic          heavy;
  logic          light;
  logic          level;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(bits[i]);
    end
  end

  assign heavy = (ones == HEAVY_C);
  assign light = (ones == LIGHT_C);
  assign level = (ones == MID_C);

  always_comb begin
    if (ones > MID_C)           rd_out = RD_POS;
    else if (ones < MID_C)      rd_out = RD_NEG;
    else if (bits == POS_PAT)   rd_out = RD_POS;
    else if (bits == NEG_PAT)   rd_out = RD_NEG;
    else                        rd_out = rd_in;
  end

  assign sign_err = (heavy && rd_in == RD_POS) || (light && rd_in == RD_NEG);
  assign code_err = !(heavy || light || level);
endmodule

// File: rtl/rd_tracker.sv
module rd_tracker
  import rd_pkg::*;
#(
  parameter int SIX_W  = 6,
  parameter int FOUR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sym_valid,
  input  logic [SIX_W+FOUR_W-1:0]   sym_in,
  output logic                      rd_cur,
  output logic                      rd_mid,
  output logic                      disp_err
);
  localparam int SYM_W = SIX_W + FOUR_W;
  localparam logic [FOUR_W-1:0] FOUR_POS = FOUR_W'((1 << (FOUR_W / 2)) - 1);
  localparam logic [SYM_W-1:0]  COMMA_A  = {SIX_W'((1 << (SIX_W - 2)) - 1), FOUR_W'(4'b1010)};

  logic rst_i_n;
  rd_e  rd_q, rd_d;
  rd_e  mid_q, mid_d;
  logic err_q, err_d;
  rd_e  six_rd, four_rd;
  logic six_sign, six_code, four_sign, four_code;

  rd_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_i_n)
  );

  rd_subblock_eval #(.W(SIX_W)) u_six (
    .bits     (sym_in[SYM_W-1:FOUR_W]),
    .rd_in    (rd_q),
    .rd_out   (six_rd),
    .sign_err (six_sign),
    .code_err (six_code)
  );

  rd_subblock_eval #(.W(FOUR_W)) u_four (
    .bits     (sym_in[FOUR_W-1:0]),
    .rd_in    (six_rd),
    .rd_out   (four_rd),
    .sign_err (four_sign),
    .code_err (four_code)
  );

  always_comb begin
    rd_d  = four_rd;
    mid_d = six_rd;
    err_d = six_sign | six_code | four_sign | four_code;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_q  <= RD_NEG;
      mid_q <= RD_NEG;
      err_q <= 1'b0;
    end else if (sym_valid) begin
      rd_q  <= rd_d;
      mid_q <= mid_d;
      err_q <= err_d;
    end
  end

  assign rd_cur   = rd_q;
  assign rd_mid   = mid_q;
  assign disp_err = err_q;

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !sym_valid |=> ($stable(rd_cur) && $stable(rd_mid) && $stable(disp_err)));

  assert_comma_clean_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sym_valid && sym_in == COMMA_A && rd_cur == 1'b0) |=> (!disp_err && rd_cur));

  assert_wide_imbalance_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sym_valid && ($countones(sym_in[SYM_W-1:FOUR_W]) > SIX_W / 2 + 1)) |=> disp_err);

  assert_four_force_pos_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sym_valid && sym_in[FOUR_W-1:0] == FOUR_POS) |=> rd_cur);
endmodule

// File: tb/rd_tracker_tb.sv
`timescale 1ns/1ps
module rd_tracker_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sym_valid;
  logic [9:0] sym_in;
  logic       rd_cur, rd_mid, disp_err;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  m_rd;

  always #4 clk = ~clk;

  rd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_in(sym_in),
    .rd_cur(rd_cur), .rd_mid(rd_mid), .disp_err(disp_err)
  );

  function automatic void eval_grp(input int w, input int b, input bit rin,
                                   output bit rout, output bit sgn, output bit bad);
    int c = 0;
    int half = w / 2;
    int pos = (1 << half) - 1;
    int neg = ((1 << w) - 1) ^ pos;
    for (int i = 0; i < w; i++) c += (b >> i) & 1;
    bad = (c != half) && (c != half - 1) && (c != half + 1);
    sgn = (c == half + 1 && rin) || (c == half - 1 && !rin);
    if (c > half) rout = 1'b1;
    else if (c < half) rout = 1'b0;
    else if (b == pos) rout = 1'b1;
    else if (b == neg) rout = 1'b0;
    else rout = rin;
  endfunction

  function automatic string grp_tag(input int w, input int b);
    int c = 0;
    int half = w / 2;
    int pos = (1 << half) - 1;
    int neg = ((1 << w) - 1) ^ pos;
    for (int i = 0; i < w; i++) c += (b >> i) & 1;
    if (c != half) return "R3";
    if (b == pos || b == neg) return (w == 6) ? "R4" : "R5";
    return "R6";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [9:0] s);
    bit mid, fin, s6, b6, s4, b4;
    eval_grp(6, int'(s[9:4]), m_rd, mid, s6, b6);
    eval_grp(4, int'(s[3:0]), mid, fin, s4, b4);
    @(negedge clk);
    sym_valid = 1'b1;
    sym_in    = s;
    @(negedge clk);
    sym_valid = 1'b0;
    m_rd = fin;
    chk({"R2/", grp_tag(6, int'(s[9:4])), " rd_mid"}, int'(rd_mid), int'(mid));
    chk({"R2/", grp_tag(4, int'(s[3:0])), " rd_cur"}, int'(rd_cur), int'(fin));
    chk((b6 || b4) ? "R8 disp_err" : "R7 disp_err", int'(disp_err), int'(s6 | b6 | s4 | b4));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sym_valid = 1'b0;
    sym_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_rd = 1'b0;
    chk("R1 rd_cur", int'(rd_cur), 0);
    chk("R1 rd_mid", int'(rd_mid), 0);
    chk("R1 disp_err", int'(disp_err), 0);
  endtask

  initial begin
    #(8.0 * 300000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sym_valid = 1'b0;
    sym_in = '0;
    m_rd = 1'b0;
    do_reset();

    // R10: alternating comma stream from negative disparity
    for (int k = 0; k < 20; k++) begin
      send((k % 2 == 0) ? 10'b0011111010 : 10'b1100000101);
      chk("R10 comma rd", int'(rd_cur), (k % 2 == 0) ? 1 : 0);
    end

    // Exhaustive sweep: every symbol from both entering disparities
    for (int s = 0; s < 1024; s++) begin
      for (int d = 0; d < 2; d++) begin
        if (m_rd != d[0]) send(d[0] ? 10'b0001110011 : 10'b1110001100);
        chk("R2 entering rd", int'(rd_cur), d);
        send(10'(s));
        if ((s % 8) == 0) begin
          logic r0, m0, e0;
          r0 = rd_cur; m0 = rd_mid; e0 = disp_err;
          @(negedge clk);
          sym_in = ~10'(s);
          @(negedge clk);
          sym_in = 10'(s);
          @(negedge clk);
          chk("R9 hold rd_cur", int'(rd_cur), int'(r0));
          chk("R9 hold rd_mid", int'(rd_mid), int'(m0));
          chk("R9 hold disp_err", int'(disp_err), int'(e0));
        end
      end
    end

    // R1: reset after traffic left positive disparity and an error
    send(10'b1111110011);
    do_reset();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule